// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is the digital half of a processor supervisor. It turns a digitized supply comparator flag into a timed power-on and brownout reset, and it watches a strobe line from the processor so that a stalled program is reset. It also gates a memory chip-enable while the supply is low and passes a power-fail warning through. Every delay is counted in ticks of a timebase. The timebase is either a nominal 10.24 kHz internal oscillator tick or a tick from an external clock, and a select input picks between them.

The block assumes the processor may need a long time to initialise. After any reset it therefore arms a long watchdog timeout. The normal period applies only after the processor has shown life with its first strobe edge. A watchdog-enable input models the strobe being left floating or at mid-supply, which turns the watchdog off. A battery flag marks the backup condition. In that condition every output goes to its safe level and the processor-side inputs are ignored.

Top module: `sup_ctrl`

## Requirements
- R1: `rst_n_o` goes low in the same cycle that `low_line_i` or `batt_i` is 1. After `low_line_i` returns to 0 it passes a two-flop synchronizer, and `rst_n_o` then stays low for 512 further selected ticks.
- R2: `rst_o` is the complement of `rst_n_o` in every cycle.
- R3: `low_line_n_o` equals NOT(`low_line_i` OR `batt_i`), with no register in the path.
- R4: At the end of each reset the watchdog limit is the post-reset value: 4096 ticks with the external timebase (`tb_int_i`=0) or 16384 ticks with the internal one (`tb_int_i`=1). This limit stays in force until the first strobe edge after reset ends.
- R5: A strobe edge loads the normal limit. This is 1024 ticks with the external timebase. With the internal timebase it is 1024 ticks if `per_long_i`=0 and 16384 ticks if `per_long_i`=1. The selects are sampled only when the timer restarts.
- R6: A rising or a falling edge of `strobe_i` restarts the count. The strobe passes two synchronizer flops and one edge-detect flop.
- R7: When the count reaches the limit, a reset of 512 ticks is issued and `wd_ok_o` goes low. `wd_ok_o` stays low until the next strobe edge. Without strobe edges the timeout repeats after every reset.
- R8: While `wd_en_i`=0 no timeout occurs, the count is held at zero and `wd_ok_o` is 1.
- R9: `wd_ok_o` is 1 while `low_line_i` is 1. The watchdog count restarts at the end of every reset, whatever caused it.
- R10: `ce_n_o` equals `ce_n_i` while the supply is good, and is 1 while `low_line_i` or `batt_i` is 1.
- R11: While `batt_i`=1: `rst_n_o`=0, `low_line_n_o`=0, `wd_ok_o`=1, `ce_n_o`=1 and `pf_n_o`=0, and strobe, chip-enable and timebase selects have no effect. Outside battery mode `pf_n_o` equals `pf_ok_i`.
- R12: After `rst_n` the block starts in reset, counting 512 ticks, and the post-reset limit is armed at the end of that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous logic reset, active low |
| tick_int_i | input | 1 | One-cycle tick from the internal oscillator |
| tick_ext_i | input | 1 | One-cycle tick from the external clock |
| tb_int_i | input | 1 | 1 selects the internal timebase, 0 the external one |
| per_long_i | input | 1 | Normal period select for the internal timebase (1 = long) |
| low_line_i | input | 1 | Supply comparator flag, 1 = below threshold (asynchronous) |
| batt_i | input | 1 | Battery backup flag, synchronous to clk |
| strobe_i | input | 1 | Watchdog strobe from the processor (asynchronous) |
| wd_en_i | input | 1 | 1 = strobe driven, watchdog enabled |
| ce_n_i | input | 1 | Chip-enable request, active low |
| pf_ok_i | input | 1 | Power-fail comparator flag, 1 = input above threshold |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| low_line_n_o | output | 1 | Low-line status, low when the supply is low |
| wd_ok_o | output | 1 | Watchdog status, low after a timeout |
| ce_n_o | output | 1 | Gated chip-enable, active low |
| pf_n_o | output | 1 | Power-fail warning, low on failure |

## Verification
On every cycle the assertions check the combinational forcing of the outputs by the low-line and battery flags. They also check that the two reset outputs stay complementary, and that a watchdog status fall only happens while enabled and only together with an asserted reset. The exact lengths need the bench's cycle-by-cycle model: the reset stretch after the flag clears, the long post-reset window, the switch to the normal period at the first strobe edge, and the latching of the period select at restart. The same holds for the repeated pulses when the strobe stays still and for the status recovery on the next edge.

// File: rtl/sup_pkg.sv
package sup_pkg;

   typedef enum logic {
      TB_EXTERNAL = 1'b0,
      TB_INTERNAL = 1'b1
   } timebase_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sup_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
   parameter int unsigned RST_TICKS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic tick_i,
   input  logic expire_i,
   output logic in_rst_o,
   output logic done_o
);

   localparam int unsigned RW = (RST_TICKS > 2) ? $clog2(RST_TICKS) : 1;
   localparam logic [RW-1:0] LAST = RW'(RST_TICKS - 1);

   logic [RW-1:0] cnt_q;
   logic          in_rst_q;

   generate
      if (RST_TICKS < 2) begin : g_bad_len
         $error("RST_TICKS must be at least 2");
      end
   endgenerate

   assign done_o   = in_rst_q && !hold_i && tick_i && (cnt_q == LAST);
   assign in_rst_o = in_rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_rst_q <= 1'b1;
         cnt_q    <= '0;
      end else if (hold_i || expire_i) begin
         in_rst_q <= 1'b1;
         cnt_q    <= '0;
      end else if (in_rst_q && tick_i) begin
         if (cnt_q == LAST) begin
            in_rst_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + RW'(1);
         end
      end
   end

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
   parameter int unsigned CW        = 15,
   parameter int unsigned EXT_NORM  = 1024,
   parameter int unsigned EXT_POST  = 4096,
   parameter int unsigned INT_SHORT = 1024,
   parameter int unsigned INT_LONG  = 16384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic in_rst_i,
   input  logic rst_done_i,
   input  logic tick_i,
   input  logic strobe_edge_i,
   input  logic en_i,
   input  logic tb_int_i,
   input  logic per_long_i,
   output logic expire_o,
   output logic ok_o
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_q;
   logic [CW-1:0] post_lim;
   logic [CW-1:0] norm_lim;
   logic          at_limit;

   always_comb begin
      post_lim = tb_int_i ? CW'(INT_LONG) : CW'(EXT_POST);
      if (tb_int_i) norm_lim = per_long_i ? CW'(INT_LONG) : CW'(INT_SHORT);
      else          norm_lim = CW'(EXT_NORM);
   end

   assign at_limit = (cnt_q == (lim_q - CW'(1)));
   assign expire_o = !in_rst_i && !hold_i && en_i && !strobe_edge_i && tick_i && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
         ok_o  <= 1'b1;
      end else if (hold_i) begin
         cnt_q <= '0;
         ok_o  <= 1'b1;
      end else if (rst_done_i) begin
         cnt_q <= '0;
         lim_q <= post_lim;
      end else if (in_rst_i) begin
         if (strobe_edge_i && en_i) ok_o <= 1'b1;
      end else if (!en_i) begin
         cnt_q <= '0;
         ok_o  <= 1'b1;
      end else if (strobe_edge_i) begin
         cnt_q <= '0;
         lim_q <= norm_lim;
         ok_o  <= 1'b1;
      end else if (tick_i) begin
         if (at_limit) begin
            cnt_q <= '0;
            ok_o  <= 1'b0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
   import sup_pkg::*;
#(
   parameter int unsigned RST_TICKS   = 512,
   parameter int unsigned EXT_NORM    = 1024,
   parameter int unsigned EXT_POST    = 4096,
   parameter int unsigned INT_SHORT   = 1024,
   parameter int unsigned INT_LONG    = 16384,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_int_i,
   input  logic tick_ext_i,
   input  logic tb_int_i,
   input  logic per_long_i,
   input  logic low_line_i,
   input  logic batt_i,
   input  logic strobe_i,
   input  logic wd_en_i,
   input  logic ce_n_i,
   input  logic pf_ok_i,
   output logic rst_n_o,
   output logic rst_o,
   output logic low_line_n_o,
   output logic wd_ok_o,
   output logic ce_n_o,
   output logic pf_n_o
);

   localparam int unsigned WMAX = max_u(max_u(EXT_NORM, EXT_POST), max_u(INT_SHORT, INT_LONG));
   localparam int unsigned CW   = $clog2(WMAX + 1);

   generate
      if (EXT_NORM < 2 || EXT_POST < 2 || INT_SHORT < 2 || INT_LONG < 2) begin : g_bad_lim
         $error("watchdog limits must be at least 2 ticks");
      end
   endgenerate

   logic ll_s, st_s, st_prev_q;
   logic strobe_edge, tick, hold;
   logic in_rst, rst_done, expire, wd_ok_q;
   timebase_e tb;

   sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ll_sync (
      .clk(clk), .rst_n(rst_n), .d_i(low_line_i), .q_o(ll_s));

   sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_st_sync (
      .clk(clk), .rst_n(rst_n), .d_i(strobe_i), .q_o(st_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_prev_q <= 1'b0;
      else        st_prev_q <= st_s;
   end

   assign strobe_edge = st_s ^ st_prev_q;
   assign tb          = timebase_e'(tb_int_i);
   assign tick        = (tb == TB_INTERNAL) ? tick_int_i : tick_ext_i;
   assign hold        = ll_s | batt_i;

   sup_rst_timer #(.RST_TICKS(RST_TICKS)) u_rst (
      .clk(clk), .rst_n(rst_n), .hold_i(hold), .tick_i(tick),
      .expire_i(expire), .in_rst_o(in_rst), .done_o(rst_done));

   sup_wdog #(
      .CW(CW), .EXT_NORM(EXT_NORM), .EXT_POST(EXT_POST),
      .INT_SHORT(INT_SHORT), .INT_LONG(INT_LONG)
   ) u_wd (
      .clk(clk), .rst_n(rst_n), .hold_i(hold), .in_rst_i(in_rst),
      .rst_done_i(rst_done), .tick_i(tick), .strobe_edge_i(strobe_edge),
      .en_i(wd_en_i), .tb_int_i(tb_int_i), .per_long_i(per_long_i),
      .expire_o(expire), .ok_o(wd_ok_q));

   assign rst_n_o      = !(in_rst || low_line_i || batt_i);
   assign rst_o        = !rst_n_o;
   assign low_line_n_o = !(low_line_i || batt_i);
   assign wd_ok_o      = wd_ok_q || low_line_i || batt_i;
   assign ce_n_o       = ce_n_i || low_line_i || batt_i;
   assign pf_n_o       = pf_ok_i && !batt_i;

endmodule

// File: rtl/sup_ctrl_chk.sv
module sup_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic low_line_i,
   input logic batt_i,
   input logic wd_en_i,
   input logic rst_n_o,
   input logic rst_o,
   input logic low_line_n_o,
   input logic wd_ok_o,
   input logic ce_n_o,
   input logic pf_n_o
);

   assert_rst_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o != rst_n_o);

   assert_ll_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      low_line_i |-> !rst_n_o);

   assert_ll_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
      low_line_i |-> !low_line_n_o);

   assert_ll_wdok_R9: assert property (@(posedge clk) disable iff (!rst_n)
      low_line_i |-> wd_ok_o);

   assert_ll_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      low_line_i |-> ce_n_o);

   assert_batt_safe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      batt_i |-> (!rst_n_o && !low_line_n_o && wd_ok_o && ce_n_o && !pf_n_o));

   assert_timeout_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_ok_o) |-> $past(wd_en_i));

   assert_timeout_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_ok_o) |-> !rst_n_o);

endmodule

bind sup_ctrl sup_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .low_line_i(low_line_i), .batt_i(batt_i),
   .wd_en_i(wd_en_i), .rst_n_o(rst_n_o), .rst_o(rst_o),
   .low_line_n_o(low_line_n_o), .wd_ok_o(wd_ok_o), .ce_n_o(ce_n_o),
   .pf_n_o(pf_n_o));

// File: tb/sup_ctrl_tb.sv
module sup_ctrl_tb;

   localparam time CLK_PERIOD = 10ns;
   localparam int  RST_LEN    = 512;
   localparam int  EXT_N      = 1024;
   localparam int  EXT_P      = 4096;
   localparam int  INT_S      = 1024;
   localparam int  INT_L      = 16384;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_int_i = 1'b0, tick_ext_i = 1'b0, tb_int_i = 1'b0, per_long_i = 1'b0;
   logic low_line_i = 1'b0, batt_i = 1'b0, strobe_i = 1'b0, wd_en_i = 1'b1;
   logic ce_n_i = 1'b1, pf_ok_i = 1'b1;
   logic rst_n_o, rst_o, low_line_n_o, wd_ok_o, ce_n_o, pf_n_o;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;
   int cyc     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sup_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .tick_int_i(tick_int_i), .tick_ext_i(tick_ext_i),
      .tb_int_i(tb_int_i), .per_long_i(per_long_i), .low_line_i(low_line_i),
      .batt_i(batt_i), .strobe_i(strobe_i), .wd_en_i(wd_en_i), .ce_n_i(ce_n_i),
      .pf_ok_i(pf_ok_i), .rst_n_o(rst_n_o), .rst_o(rst_o),
      .low_line_n_o(low_line_n_o), .wd_ok_o(wd_ok_o), .ce_n_o(ce_n_o),
      .pf_n_o(pf_n_o));

   // Behavioural reference: remaining-tick countdowns and sample histories.
   bit ll_hist[$];
   bit st_hist[$];
   bit m_in_rst;
   int m_rst_left;
   int m_wd_left;
   int m_wd_len;
   bit m_ok;

   task automatic model_init();
      ll_hist = '{1'b1, 1'b1};
      st_hist = '{1'b0, 1'b0, 1'b0};
      m_in_rst = 1'b1; m_rst_left = RST_LEN;
      m_wd_left = 0; m_wd_len = 0; m_ok = 1'b1;
   endtask

   initial model_init();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_init();
      end else begin
         bit tk, hld, edg, was_rst, finish_rst, timeout;
         tk  = tb_int_i ? tick_int_i : tick_ext_i;
         hld = ll_hist[1] || batt_i;
         edg = (st_hist[1] != st_hist[2]);
         was_rst    = m_in_rst;
         finish_rst = was_rst && !hld && tk && (m_rst_left == 1);
         timeout    = !was_rst && !hld && wd_en_i && !edg && tk && (m_wd_left == 1);
         if (hld) begin
            m_ok = 1'b1; m_wd_left = m_wd_len;
         end else if (finish_rst) begin
            m_wd_len  = tb_int_i ? INT_L : EXT_P;
            m_wd_left = m_wd_len;
         end else if (was_rst) begin
            if (edg && wd_en_i) m_ok = 1'b1;
         end else if (!wd_en_i) begin
            m_wd_left = m_wd_len; m_ok = 1'b1;
         end else if (edg) begin
            m_wd_len  = tb_int_i ? (per_long_i ? INT_L : INT_S) : EXT_N;
            m_wd_left = m_wd_len; m_ok = 1'b1;
         end else if (tk) begin
            if (m_wd_left == 1) begin m_wd_left = m_wd_len; m_ok = 1'b0; end
            else m_wd_left--;
         end
         if (hld || timeout) begin
            m_in_rst = 1'b1; m_rst_left = RST_LEN;
         end else if (was_rst && tk) begin
            if (m_rst_left == 1) m_in_rst = 1'b0;
            else m_rst_left--;
         end
         void'(ll_hist.pop_back()); ll_hist.push_front(low_line_i);
         void'(st_hist.pop_back()); st_hist.push_front(strobe_i);
      end
   end

   task automatic cmp(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
      end
   endtask

   task automatic compare_all(input string ctx);
      logic e_rstn;
      e_rstn = !(m_in_rst || low_line_i || batt_i);
      cmp({"R1 rst_n_o ", ctx}, rst_n_o, e_rstn);
      cmp({"R2 rst_o ", ctx}, rst_o, !e_rstn);
      cmp({"R3 low_line_n_o ", ctx}, low_line_n_o, !(low_line_i || batt_i));
      cmp({"R7 wd_ok_o ", ctx}, wd_ok_o, m_ok || low_line_i || batt_i);
      cmp({"R10 ce_n_o ", ctx}, ce_n_o, ce_n_i || low_line_i || batt_i);
      cmp({"R11 pf_n_o ", ctx}, pf_n_o, pf_ok_i && !batt_i);
   endtask

   always @(negedge clk) begin
      #1;
      if (!done) compare_all("every-cycle");
   end

   // Stimulus: ticks generated per cycle, inputs change on the falling edge.
   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cyc++;
         tick_ext_i = 1'b1;
         tick_int_i = (cyc % 2 == 0);
      end
   endtask

   task automatic toggle_strobe();
      @(negedge clk);
      strobe_i = ~strobe_i;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      run(4);
      rst_n = 1'b1;
      run(2);
      // R12: logic reset leaves the block in reset
      cmp("R12 reset state rst_n_o", rst_n_o, 1'b0);
      cmp("R12 reset state wd_ok_o", wd_ok_o, 1'b1);
      run(600);
      compare_all("R12 after first reset");
      cmp("R12 released", rst_n_o, 1'b1);

      // R4: no strobe -> post-reset long timeout, then R7 pulse
      run(EXT_P + 20);
      compare_all("R4 post-reset timeout");
      run(RST_LEN + 20);

      // R6/R5: edges both directions restart, normal period 1024
      for (int k = 0; k < 6; k++) begin
         toggle_strobe();
         run(700);
         compare_all("R6 strobe restarts");
      end
      run(EXT_N + 10);
      compare_all("R7 timeout after normal period");
      cmp("R7 status low", wd_ok_o, 1'b0);
      run(RST_LEN + 50);
      cmp("R7 status latched low", wd_ok_o, 1'b0);
      toggle_strobe();
      run(5);
      cmp("R7 status restored on edge", wd_ok_o, 1'b1);

      // R9: low-line mid-run forces status, count restarts after reset
      run(300);
      @(negedge clk); low_line_i = 1'b1;
      run(20);
      compare_all("R9 low-line held");
      @(negedge clk); low_line_i = 1'b0;
      run(RST_LEN + 10);
      compare_all("R1 stretch after low-line");

      // R8: disabled watchdog never times out
      @(negedge clk); wd_en_i = 1'b0;
      run(EXT_P + 2000);
      cmp("R8 no timeout when disabled", rst_n_o, 1'b1);
      cmp("R8 status high when disabled", wd_ok_o, 1'b1);
      @(negedge clk); wd_en_i = 1'b1;
      toggle_strobe();

      // R10: chip-enable gating
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); ce_n_i = k[0];
         #2 compare_all("R10 ce pass");
      end
      @(negedge clk); low_line_i = 1'b1; ce_n_i = 1'b0;
      #2 cmp("R10 gated high on low-line", ce_n_o, 1'b1);
      @(negedge clk); low_line_i = 1'b0;
      run(RST_LEN + 10);

      // R11: battery mode ignores strobe, ce and selects
      @(negedge clk); batt_i = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk); strobe_i = ~strobe_i; ce_n_i = ~ce_n_i;
         pf_ok_i = ~pf_ok_i; tb_int_i = ~tb_int_i;
         #2 compare_all("R11 battery");
         cmp("R11 pf forced low", pf_n_o, 1'b0);
      end
      @(negedge clk); batt_i = 1'b0; tb_int_i = 1'b0; pf_ok_i = 1'b1; ce_n_i = 1'b1;
      run(RST_LEN + 10);
      cmp("R11 pf follows outside battery", pf_n_o, 1'b1);

      // R5: internal timebase, short then long normal period
      @(negedge clk); tb_int_i = 1'b1; per_long_i = 1'b0;
      toggle_strobe();
      run(2 * INT_S + 40);
      compare_all("R5 internal short timeout");
      run(2 * RST_LEN + 40);
      toggle_strobe();
      run(2 * INT_S - 200);
      @(negedge clk); per_long_i = 1'b1;  // takes effect only at next restart
      run(300);
      compare_all("R5 select latched at restart");
      run(2 * RST_LEN + 40);
      toggle_strobe();
      run(2 * INT_S + 400);
      cmp("R5 long normal period no early timeout", rst_n_o, 1'b1);
      run(2 * INT_L);
      compare_all("R5 long normal timeout");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule